// File: doc/BRIEF.md
# Labelled Read Arbiter for Ray Core Clients

This block lets a group of ray tracing cores share one read-only data memory port. Each core (client) offers a read with an address. The block accepts one of these offers per cycle, chosen in round-robin order. It labels the accepted read with the client's index and scrambles the address before passing it to memory. The scrambling folds high address bits into the bank-select bits, so that strided access patterns are spread across banks.

Memory replies with a fixed latency and no back-pressure. Each reply carries the label it was issued with. The block registers the reply once and broadcasts it on a single shared return bus. A one-hot strobe tells each client whether the word on the bus is its own.

Request handshake rules:
- A client holds `req_valid` and its address steady until its hit strobe rises.
- A request only moves when `req_valid` and `req_ready` are both high at a clock edge.
- The memory side uses `mem_req_valid`/`mem_req_ready` in the same way. `mem_req_valid` never waits on `mem_req_ready`.
- A client that keeps `req_valid` high in the cycle its hit strobe is high is offering a new request.

The client count is meant to be between 8 and 16. The label width is the ceiling of log2 of that count.

Top module: `ray_mem_arbiter`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rsp_hit` is all zeros. The round-robin search starts at client 0.
- R2: `mem_req_valid` is 1 exactly when some client has `req_valid` high and no read outstanding. `mem_req_tag` carries the index of the selected client.
- R3: The client selected is the first eligible one at or after the search start, wrapping from the last client to client 0. After an accepted request from client k, the search start moves to k+1 (wrapping to 0 after the last client). With all clients requesting and memory ready, consecutive grants go to consecutive indices.
- R4: A client whose read has been accepted is never granted again until its reply has been broadcast. At most one `req_ready` bit is high in any cycle.
- R5: `mem_req_addr` equals the selected client's address, except that bits [BANK_W-1:0] are XORed with the top BANK_W bits. For example, with a 16-bit address and BANK_W = 3, address 0xE005 goes out as 0xE002.
- R6: When memory returns a reply, the next cycle shows it on the shared bus:
  - `rsp_valid` = 1;
  - `rsp_tag` and `rsp_data` equal the returned label and data;
  - only the `rsp_hit` bit indexed by the label is set.
  
  In cycles with no reply, `rsp_hit` is zero.
- R7: While `mem_req_ready` is 0, every `req_ready` bit is 0 and the round-robin search start does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_CLIENTS | Per-client read request valid |
| req_ready | output | NUM_CLIENTS | Per-client request accepted this cycle |
| req_addr | input | NUM_CLIENTS*ADDR_W | Client addresses, client i in bits [i*ADDR_W +: ADDR_W] |
| mem_req_valid | output | 1 | Read request to memory valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Hashed read address |
| mem_req_tag | output | TAG_W | Label (client index) of the request |
| mem_rsp_valid | input | 1 | Memory reply valid |
| mem_rsp_tag | input | TAG_W | Label returned with the reply |
| mem_rsp_data | input | DATA_W | Reply data |
| rsp_valid | output | 1 | Shared return bus valid |
| rsp_tag | output | TAG_W | Label on the shared return bus |
| rsp_data | output | DATA_W | Data on the shared return bus |
| rsp_hit | output | NUM_CLIENTS | One-hot: reply on the bus belongs to client i |

## Verification
The grant, label and hashed address are combinational from the current inputs and the stored pointer and outstanding mask. The bench drives each cycle's inputs at the falling edge, waits briefly, and compares them with a bench model in that same cycle. A reply driven into `mem_rsp_*` appears on the shared bus one clock edge later. The bench records the expected reply when it drives memory and checks it at the next falling edge. The memory model answers three cycles after each accepted request. The data it returns is a fixed function of the un-hashed address, so a wrong hash or a wrong label shows up as wrong data at the owning client.

// File: rtl/rma_pkg.sv
package rma_pkg;
  localparam int MIN_CLIENTS = 8;
  localparam int MAX_CLIENTS = 16;

  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rma_rr_picker.sv
module rma_rr_picker #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [IDX_W-1:0] start,
  input  logic [N-1:0]     elig,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  int cand;

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    cand  = 0;
    for (int off = 0; off < N; off++) begin
      if (!any) begin
        cand = int'(start) + off;
        if (cand >= N) cand = cand - N;
        if (elig[cand]) begin
          any         = 1'b1;
          idx         = IDX_W'(cand);
          grant[cand] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rma_addr_hash.sv
module rma_addr_hash #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  assign addr_out = {addr_in[ADDR_W-1:BANK_W],
                     addr_in[BANK_W-1:0] ^ addr_in[ADDR_W-1 -: BANK_W]};
endmodule

// File: rtl/rma_tag_broadcast.sv
module rma_tag_broadcast #(
  parameter int N      = 8,
  parameter int TAG_W  = $clog2(N),
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic [N-1:0]      out_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_tag  <= in_tag;
        out_data <= in_data;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_hit[i] <= 1'b0;
      else        out_hit[i] <= in_valid && (in_tag == TAG_W'(i));
    end
  end

  // R6: a reply is on the bus the cycle after it arrives
  a_r6_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_tag == $past(in_tag) && out_data == $past(in_data)));
  // R6: exactly one client strobed per reply, none otherwise
  a_r6_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot(out_hit) && out_hit[out_tag]));
  a_r6_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_hit == '0));
endmodule

// File: rtl/ray_mem_arbiter.sv
module ray_mem_arbiter #(
  parameter int NUM_CLIENTS = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BANK_W      = 3,
  localparam int TAG_W      = $clog2(NUM_CLIENTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CLIENTS-1:0]        req_valid,
  output logic [NUM_CLIENTS-1:0]        req_ready,
  input  logic [NUM_CLIENTS*ADDR_W-1:0] req_addr,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [TAG_W-1:0]              mem_req_tag,
  input  logic                          mem_rsp_valid,
  input  logic [TAG_W-1:0]              mem_rsp_tag,
  input  logic [DATA_W-1:0]             mem_rsp_data,
  output logic                          rsp_valid,
  output logic [TAG_W-1:0]              rsp_tag,
  output logic [DATA_W-1:0]             rsp_data,
  output logic [NUM_CLIENTS-1:0]        rsp_hit
);
  logic [TAG_W-1:0]       rr_ptr;
  logic [NUM_CLIENTS-1:0] issued;
  logic [NUM_CLIENTS-1:0] elig;
  logic [NUM_CLIENTS-1:0] grant;
  logic [TAG_W-1:0]       gidx;
  logic                   any_elig;
  logic                   accept;
  logic [ADDR_W-1:0]      addr_arr [NUM_CLIENTS];
  logic [ADDR_W-1:0]      sel_addr;

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_unpack
    assign addr_arr[i] = req_addr[i*ADDR_W +: ADDR_W];
  end

  assign elig = req_valid & ~issued;

  rma_rr_picker #(.N(NUM_CLIENTS), .IDX_W(TAG_W)) u_pick (
    .start(rr_ptr), .elig(elig), .grant(grant), .idx(gidx), .any(any_elig)
  );

  assign sel_addr      = addr_arr[gidx];
  assign mem_req_valid = any_elig;
  assign mem_req_tag   = gidx;
  assign accept        = any_elig && mem_req_ready;
  assign req_ready     = mem_req_ready ? grant : '0;

  rma_addr_hash #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_hash (
    .addr_in(sel_addr), .addr_out(mem_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_ptr <= '0;
    else if (accept) rr_ptr <= TAG_W'(rma_pkg::wrap_next(int'(gidx), NUM_CLIENTS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued <= '0;
    end else begin
      for (int i = 0; i < NUM_CLIENTS; i++) begin
        if (accept && gidx == TAG_W'(i))                 issued[i] <= 1'b1;
        else if (mem_rsp_valid && mem_rsp_tag == TAG_W'(i)) issued[i] <= 1'b0;
      end
    end
  end

  rma_tag_broadcast #(.N(NUM_CLIENTS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bcast (
    .clk(clk), .rst_n(rst_n),
    .in_valid(mem_rsp_valid), .in_tag(mem_rsp_tag), .in_data(mem_rsp_data),
    .out_valid(rsp_valid), .out_tag(rsp_tag), .out_data(rsp_data), .out_hit(rsp_hit)
  );

  // R4: single grant, never to a client already waiting on memory
  a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r4_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & issued) == '0);
  // R3: the labelled client really is requesting
  a_r3_label_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (req_valid[mem_req_tag] && !issued[mem_req_tag]));
  // R5: hash leaves the upper address bits untouched
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ADDR_W-1:BANK_W] == sel_addr[ADDR_W-1:BANK_W]));
  // R7: stalled memory freezes the round-robin position
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_ready |=> $stable(rr_ptr));
endmodule

// File: tb/ray_mem_arbiter_test.sv
`timescale 1ns/1ps
module ray_mem_arbiter_test;
  localparam int N = 8, AW = 16, DW = 32, BW = 3, TW = 3, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0, req_ready, rsp_hit;
  logic [N*AW-1:0] req_addr = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag, mem_rsp_tag = '0, rsp_tag;
  logic [DW-1:0] mem_rsp_data = '0, rsp_data;

  always #4 clk = ~clk;

  ray_mem_arbiter #(.NUM_CLIENTS(N), .ADDR_W(AW), .DATA_W(DW), .BANK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_hit(rsp_hit));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] b_pend = '0, b_iss = '0;
  int b_ptr = 0;
  logic [AW-1:0] b_addr [N];
  logic pv [LAT];
  logic [TW-1:0] pt [LAT];
  logic [AW-1:0] pa [LAT];
  logic exp_rv = 0;
  logic [TW-1:0] exp_rt = '0;
  logic [DW-1:0] exp_rd = '0;
  int last_tag;

  function automatic logic [AW-1:0] hash_fn(input logic [AW-1:0] a);
    logic [AW-1:0] h = a;
    h[BW-1:0] = a[BW-1:0] ^ a[AW-1 -: BW];
    return h;
  endfunction

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  function automatic int rr_pick(input logic [N-1:0] e, input int p);
    for (int off = 0; off < N; off++) if (e[(p + off) % N]) return (p + off) % N;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // mode 0: random, 1: every idle client requests, memory ready; 2: no new requests, memory ready
  task automatic step(input int mode);
    logic [N-1:0] e;
    int g;
    bit hs;
    @(negedge clk);
    chk(rsp_valid == exp_rv, "R6 rsp_valid", rsp_valid, exp_rv);
    if (exp_rv) begin
      chk(rsp_tag == exp_rt, "R6 rsp_tag", rsp_tag, exp_rt);
      chk(rsp_data == exp_rd, "R6 rsp_data", rsp_data, exp_rd);
      chk(rsp_hit == (N'(1) << exp_rt), "R6 rsp_hit", rsp_hit, N'(1) << exp_rt);
      b_pend[exp_rt] = 1'b0;
      b_iss[exp_rt]  = 1'b0;
    end else begin
      chk(rsp_hit == '0, "R6 idle hit", rsp_hit, 0);
    end
    for (int i = 0; i < N; i++) begin
      if (!b_pend[i] && (mode == 1 || (mode == 0 && $urandom % 4 == 0))) begin
        b_addr[i] = ($urandom % 3 == 0) ? AW'(($urandom % 8) << 13) : AW'($urandom);
        b_pend[i] = 1'b1;
      end
      req_valid[i] = b_pend[i];
      req_addr[i*AW +: AW] = b_addr[i];
    end
    mem_req_ready = (mode != 0) ? 1'b1 : ($urandom % 4 != 0);
    mem_rsp_valid = pv[LAT-1];
    mem_rsp_tag   = pt[LAT-1];
    mem_rsp_data  = mem_fn(hash_fn(pa[LAT-1]));
    exp_rv = pv[LAT-1];
    exp_rt = pt[LAT-1];
    exp_rd = mem_fn(b_addr[pt[LAT-1]]);
    #1;
    e = b_pend & ~b_iss;
    g = rr_pick(e, b_ptr);
    chk(mem_req_valid == (e != '0), "R2 mem_req_valid", mem_req_valid, e != '0);
    chk((req_ready & b_iss) == '0, "R4 no reissue", req_ready, 0);
    if (g >= 0) begin
      chk(mem_req_tag == TW'(g), "R3 rr choice", mem_req_tag, g);
      chk(mem_req_addr == hash_fn(b_addr[g]), "R5 hashed addr", mem_req_addr, hash_fn(b_addr[g]));
      chk(req_ready == (mem_req_ready ? (N'(1) << g) : N'(0)), "R7 req_ready",
          req_ready, mem_req_ready ? (N'(1) << g) : 0);
    end else begin
      chk(req_ready == '0, "R2 idle ready", req_ready, 0);
    end
    hs = (g >= 0) && mem_req_ready;
    for (int k = LAT - 1; k > 0; k--) begin
      pv[k] = pv[k-1]; pt[k] = pt[k-1]; pa[k] = pa[k-1];
    end
    pv[0] = hs;
    pt[0] = hs ? TW'(g) : '0;
    pa[0] = hs ? hash_fn(b_addr[g]) : '0;
    if (hs) begin
      b_iss[g] = 1'b1;
      b_ptr = (g + 1) % N;
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < LAT; k++) begin pv[k] = 0; pt[k] = '0; pa[k] = '0; end
    for (int i = 0; i < N; i++) b_addr[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid reset", rsp_valid, 0);
    chk(rsp_hit == '0, "R1 rsp_hit reset", rsp_hit, 0);
    rst_n = 1'b1;
    // R1/R3: all clients at once after reset, grants run 0,1,2,...
    last_tag = -1;
    for (int c = 0; c < N; c++) begin
      step(1);
      if (c == 0) chk(mem_req_tag == '0, "R1 first grant", mem_req_tag, 0);
      else chk(int'(mem_req_tag) == (last_tag + 1) % N, "R3 consecutive", mem_req_tag, (last_tag + 1) % N);
      last_tag = int'(mem_req_tag);
    end
    repeat (3000) step(0);
    repeat (12) step(2);
    // R5 directed: 0xE005 -> 0xE002
    b_addr[2] = 16'hE005;
    b_pend[2] = 1'b1;
    step(2);
    chk(mem_req_tag == 3'd2, "R5 directed tag", mem_req_tag, 2);
    chk(mem_req_addr == 16'hE002, "R5 directed addr", mem_req_addr, 16'hE002);
    repeat (6) step(2);
    repeat (1000) step(0);
    repeat (12) step(2);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule